// File: doc/BRIEF.md
# Memory access fault checker

This block sits in front of a processor's load, store and instruction-fetch path and classifies each request before it reaches memory. A request carries a 32-bit address, an access size, an access kind and a select between two core variants, A and B. The block forces the address down to the natural boundary of the access size and works out whether the access raises a fault. The two variants use different sets of protected address windows, so the same address can fault on one variant and pass on the other.

Two control inputs change the rules. One suppresses the alignment error that variant A would otherwise raise. The other opens a small boot window to instruction fetch on variant B. Exactly one fault class is reported for each request. Checks run in a fixed order, and the first one that fires decides the class. The corrected address and the fault vector are registered, so they appear one clock after the request.

Top module: `mfc_fault_checker`

## Requirements
- R1: `rsp_valid_o` is high in the cycle after each clock edge at which `req_valid_i` is high, and low after each edge at which it is low. `rsp_fault_o` is zero whenever `rsp_valid_o` is low.
- R2: The access size codes are 0 byte, 1 halfword, 2 word, 3 doubleword, and 4 or higher quadword. Kind codes are 0 data read and 1 data write; 2 and 3 are both instruction fetch. `rsp_addr_o` is the request address with the low bits cleared: 0, 1, 2, 3 or 4 bits for byte, halfword, word, doubleword and quadword. A fetch always clears 2 bits, whatever its size.
- R3: The fault bits are: bit 0 not-aligned, bit 1 data access error, bit 2 data access exception, bit 3 instruction access error, bit 4 instruction access exception, bit 5 data store error. At most one bit is set. When several checks could fire, the first one in the order of R4 to R10 wins. Range checks use the aligned address, compared as an unsigned number.
- R4: On variant A (`variant_i`=0), a doubleword read whose aligned address lies in 0xFE800000..0xFEFFFFFF gives a data access error. Reads of any other size raise no fault from that range.
- R5: On variant A, a misaligned data read or write gives a data access error unless `align_mask_i` is 1. A doubleword read in the R4 window reports its R4 fault first. A write reports this fault ahead of R10. With the mask set, the address is still aligned down.
- R6: On variant B (`variant_i`=1), any misaligned read, write or fetch gives not-aligned, and this takes priority over every range check.
- R7: On variant B, a read in 0xFE800000..0xFEFEFFFF or in 0xFEFF0600..0xFEFF7FFF gives a data access error. Any other read or write in 0xFE000000..0xFE7FFFFF gives a data access exception.
- R8: On variant A, a misaligned fetch gives an instruction access error. An aligned fetch in 0xFE800000..0xFEFFFFFF also gives an instruction access error.
- R9: On variant B, a fetch in either R7 error window gives an instruction access error. Otherwise, a fetch in 0xFE004000..0xFE7FFFFF gives an instruction access exception. Otherwise, a fetch in 0xFE000000..0xFE003FFF gives that exception only when `region_en_i` is 0.
- R10: A data store error is raised by a variant A doubleword write in 0xFE800000..0xFEFFFFFF, and by a variant B write in either R7 error window.
- R11: While `rst_ni` is low, `rsp_valid_o` and `rsp_fault_o` are zero, starting from the moment reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request address |
| req_size_i | input | 3 | Access size code |
| req_kind_i | input | 2 | Access kind code |
| variant_i | input | 1 | Core variant select: 0 is A, 1 is B |
| align_mask_i | input | 1 | Suppresses the variant A alignment error |
| region_en_i | input | 1 | Opens the variant B boot window to fetch |
| rsp_valid_o | output | 1 | Registered result valid |
| rsp_addr_o | output | 32 | Aligned address |
| rsp_fault_o | output | 6 | One-hot fault vector |

## Verification
The hardest cases to reach are the priority collisions, where one request meets more than one rule at once. Examples are a misaligned doubleword write inside the variant A error window with the mask off and then on, a misaligned variant B read inside an error window, and fetches on either side of the boot-window edge with the enable bit in each state. Directed requests target each such collision and every range edge one word inside and one word outside. A random sweep then draws addresses clustered around those edges, together with random sizes, kinds, variants and control bits, so that many rule combinations occur.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int ADDR_W     = 32;
  localparam int SIZE_W     = 3;
  localparam int MAX_LG     = 4;
  localparam int FETCH_LG   = 2;
  localparam int NUM_FAULTS = 6;
  localparam int NUM_RANGES = 5;

  localparam logic [SIZE_W-1:0] SIZE_DWORD = 3'd3;
  localparam logic [1:0]        KIND_WRITE = 2'd1;

  // fault vector bit positions
  localparam int F_MISALIGN  = 0;
  localparam int F_DATA_ERR  = 1;
  localparam int F_DATA_EXC  = 2;
  localparam int F_INSN_ERR  = 3;
  localparam int F_INSN_EXC  = 4;
  localparam int F_STORE_ERR = 5;

  // window indices
  localparam int RG_A_ERR    = 0;
  localparam int RG_B_ERR_LO = 1;
  localparam int RG_B_ERR_HI = 2;
  localparam int RG_B_EXC    = 3;
  localparam int RG_BOOT     = 4;

  function automatic logic [31:0] range_lo(int idx);
    case (idx)
      RG_A_ERR:    range_lo = 32'hFE80_0000;
      RG_B_ERR_LO: range_lo = 32'hFEFF_0600;
      RG_B_ERR_HI: range_lo = 32'hFE80_0000;
      RG_B_EXC:    range_lo = 32'hFE00_4000;
      default:     range_lo = 32'hFE00_0000;
    endcase
  endfunction

  function automatic logic [31:0] range_hi(int idx);
    case (idx)
      RG_A_ERR:    range_hi = 32'hFEFF_FFFF;
      RG_B_ERR_LO: range_hi = 32'hFEFF_7FFF;
      RG_B_ERR_HI: range_hi = 32'hFEFE_FFFF;
      RG_B_EXC:    range_hi = 32'hFE7F_FFFF;
      default:     range_hi = 32'hFE00_3FFF;
    endcase
  endfunction
endpackage

// File: rtl/mfc_align.sv
module mfc_align #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 3,
  parameter int MAX_LG   = 4,
  parameter int FETCH_LG = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              fetch_i,
  output logic [ADDR_W-1:0] aligned_o,
  output logic              misaligned_o
);
  localparam int MASK_W = MAX_LG;

  logic [SIZE_W-1:0] lg;
  logic [MASK_W-1:0] mask;

  always_comb begin
    if (fetch_i)                         lg = SIZE_W'(FETCH_LG);
    else if (32'(size_i) > MAX_LG)       lg = SIZE_W'(MAX_LG);
    else                                 lg = size_i;
    mask = MASK_W'((32'd1 << lg) - 32'd1);
  end

  assign aligned_o    = addr_i & ~{{(ADDR_W-MASK_W){1'b0}}, mask};
  assign misaligned_o = |(addr_i[MASK_W-1:0] & mask);
endmodule

// File: rtl/mfc_region.sv
module mfc_region
  import mfc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int N_RANGE = 5
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_RANGE-1:0] hit_o
);
  for (genvar g = 0; g < N_RANGE; g++) begin : g_win
    assign hit_o[g] = (addr_i >= ADDR_W'(range_lo(g))) &&
                      (addr_i <= ADDR_W'(range_hi(g)));
  end
endmodule

// File: rtl/mfc_classify.sv
module mfc_classify
  import mfc_pkg::*;
(
  input  logic                  misaligned_i,
  input  logic [NUM_RANGES-1:0] hit_i,
  input  logic                  variant_i,
  input  logic [1:0]            kind_i,
  input  logic                  is_dword_i,
  input  logic                  suppress_i,
  input  logic                  region_en_i,
  output logic [NUM_FAULTS-1:0] fault_o
);
  logic fetch, write, b_err, b_common, a_mis_err;

  assign fetch     = kind_i[1];
  assign write     = (kind_i == KIND_WRITE);
  assign b_err     = hit_i[RG_B_ERR_LO] | hit_i[RG_B_ERR_HI];
  assign b_common  = hit_i[RG_B_EXC] | hit_i[RG_BOOT];
  assign a_mis_err = misaligned_i & ~suppress_i;

  // first firing check wins; order follows the access path
  always_comb begin
    fault_o = '0;
    if (fetch) begin
      if (!variant_i) begin
        if (misaligned_i)            fault_o[F_INSN_ERR] = 1'b1;
        else if (hit_i[RG_A_ERR])    fault_o[F_INSN_ERR] = 1'b1;
      end else begin
        if (misaligned_i)            fault_o[F_MISALIGN] = 1'b1;
        else if (b_err)              fault_o[F_INSN_ERR] = 1'b1;
        else if (hit_i[RG_B_EXC])    fault_o[F_INSN_EXC] = 1'b1;
        else if (hit_i[RG_BOOT] && !region_en_i)
                                     fault_o[F_INSN_EXC] = 1'b1;
      end
    end else if (write) begin
      if (!variant_i) begin
        if (a_mis_err)               fault_o[F_DATA_ERR]  = 1'b1;
        else if (is_dword_i && hit_i[RG_A_ERR])
                                     fault_o[F_STORE_ERR] = 1'b1;
      end else begin
        if (misaligned_i)            fault_o[F_MISALIGN]  = 1'b1;
        else if (b_err)              fault_o[F_STORE_ERR] = 1'b1;
        else if (b_common)           fault_o[F_DATA_EXC]  = 1'b1;
      end
    end else begin
      if (!variant_i) begin
        if (is_dword_i && hit_i[RG_A_ERR])
                                     fault_o[F_DATA_ERR] = 1'b1;
        else if (a_mis_err)          fault_o[F_DATA_ERR] = 1'b1;
      end else begin
        if (misaligned_i)            fault_o[F_MISALIGN] = 1'b1;
        else if (b_err)              fault_o[F_DATA_ERR] = 1'b1;
        else if (b_common)           fault_o[F_DATA_EXC] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfc_fault_checker.sv
module mfc_fault_checker
  import mfc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [SIZE_W-1:0]     req_size_i,
  input  logic [1:0]            req_kind_i,
  input  logic                  variant_i,
  input  logic                  align_mask_i,
  input  logic                  region_en_i,
  output logic                  rsp_valid_o,
  output logic [ADDR_W-1:0]     rsp_addr_o,
  output logic [NUM_FAULTS-1:0] rsp_fault_o
);
  logic [ADDR_W-1:0]     aligned;
  logic                  misaligned;
  logic [NUM_RANGES-1:0] hit;
  logic [NUM_FAULTS-1:0] fault_c;

  mfc_align #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_LG(MAX_LG), .FETCH_LG(FETCH_LG)
  ) i_align (
    .addr_i(req_addr_i), .size_i(req_size_i), .fetch_i(req_kind_i[1]),
    .aligned_o(aligned), .misaligned_o(misaligned)
  );

  mfc_region #(.ADDR_W(ADDR_W), .N_RANGE(NUM_RANGES)) i_region (
    .addr_i(aligned), .hit_o(hit)
  );

  mfc_classify i_classify (
    .misaligned_i(misaligned), .hit_i(hit), .variant_i(variant_i),
    .kind_i(req_kind_i), .is_dword_i(req_size_i == SIZE_DWORD),
    .suppress_i(align_mask_i), .region_en_i(region_en_i), .fault_o(fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o  <= aligned;
        rsp_fault_o <= fault_c;
      end else begin
        rsp_fault_o <= '0;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_fault_o == '0));
  // R3
  fault_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_fault_o));
  // R2
  fetch_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i[1]) |=> (rsp_addr_o[1:0] == 2'b00));
  // R4
  a_byte_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !variant_i && req_kind_i == 2'd0 && req_size_i == 3'd0)
      |=> (rsp_fault_o == '0));
  // R6
  b_misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && variant_i && req_addr_i[0] && req_size_i != 3'd0)
      |=> rsp_fault_o[F_MISALIGN]);
  // R9
  boot_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && variant_i && req_kind_i[1] && region_en_i &&
     req_addr_i[1:0] == 2'b00 && req_addr_i >= 32'hFE00_0000 &&
     req_addr_i <= 32'hFE00_3FFF) |=> (rsp_fault_o == '0));
endmodule

// File: tb/test_mfc_fault_checker.sv
module test_mfc_fault_checker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic        variant = 1'b0;
  logic        amask = 1'b0;
  logic        ren = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [5:0]  rsp_fault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit          exp_v = 0;
  logic [31:0] exp_a;
  logic [5:0]  exp_f;
  string       exp_tag;

  always #5 clk = ~clk;

  mfc_fault_checker i_mfc_fault_checker (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_kind_i(req_kind), .variant_i(variant),
    .align_mask_i(amask), .region_en_i(ren), .rsp_valid_o(rsp_valid),
    .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault)
  );

  function automatic bit inr(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic void model(input logic [31:0] addr, input logic [2:0] size,
                                input logic [1:0] kind, input bit vb, input bit msk,
                                input bit re, output logic [31:0] a,
                                output logic [5:0] f, output string tag);
    logic [31:0] m;
    bit mis, berr, bcom, dw;
    if (kind >= 2)      m = 3;
    else if (size >= 4) m = 15;
    else                m = (32'd1 << size) - 1;
    a    = addr & ~m;
    mis  = (addr & m) != 0;
    dw   = (size == 3);
    berr = inr(a, 32'hFE800000, 32'hFEFEFFFF) || inr(a, 32'hFEFF0600, 32'hFEFF7FFF);
    bcom = inr(a, 32'hFE000000, 32'hFE7FFFFF);
    f = 0; tag = "R2";
    if (kind >= 2) begin
      if (!vb) begin
        tag = "R8";
        if (mis || inr(a, 32'hFE800000, 32'hFEFFFFFF)) f = 6'b001000;
      end else if (mis) begin f = 6'b000001; tag = "R6"; end
      else begin
        tag = "R9";
        if (berr) f = 6'b001000;
        else if (inr(a, 32'hFE004000, 32'hFE7FFFFF)) f = 6'b010000;
        else if (inr(a, 32'hFE000000, 32'hFE003FFF) && !re) f = 6'b010000;
      end
    end else if (kind == 1) begin
      if (!vb) begin
        if (mis && !msk) begin f = 6'b000010; tag = "R5"; end
        else if (dw && inr(a, 32'hFE800000, 32'hFEFFFFFF)) begin f = 6'b100000; tag = "R10"; end
        else if (mis) tag = "R5";
      end else begin
        if (mis) begin f = 6'b000001; tag = "R6"; end
        else if (berr) begin f = 6'b100000; tag = "R10"; end
        else if (bcom) begin f = 6'b000100; tag = "R7"; end
      end
    end else begin
      if (!vb) begin
        if (dw && inr(a, 32'hFE800000, 32'hFEFFFFFF)) begin f = 6'b000010; tag = "R4"; end
        else if (mis && !msk) begin f = 6'b000010; tag = "R5"; end
        else tag = "R4";
      end else begin
        if (mis) begin f = 6'b000001; tag = "R6"; end
        else if (berr) begin f = 6'b000010; tag = "R7"; end
        else if (bcom) begin f = 6'b000100; tag = "R7"; end
      end
    end
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_v) begin
      failures++;
      $display("FAIL R1 valid actual=%0b expected=%0b", rsp_valid, exp_v);
    end
    if (exp_v) begin
      checks++;
      if (rsp_addr !== exp_a) begin
        failures++;
        $display("FAIL R2 addr actual=%h expected=%h", rsp_addr, exp_a);
      end
      checks++;
      if (rsp_fault !== exp_f) begin
        failures++;
        $display("FAIL %s fault actual=%b expected=%b addr=%h", exp_tag, rsp_fault, exp_f, req_addr);
      end
    end else begin
      checks++;
      if (rsp_fault !== 6'b0) begin
        failures++;
        $display("FAIL R1 idle fault actual=%b expected=000000", rsp_fault);
      end
    end
  endtask

  task automatic step(bit v, logic [31:0] addr, logic [2:0] size, logic [1:0] kind,
                      bit vb, bit msk, bit re);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = addr; req_size = size; req_kind = kind;
    variant = vb; amask = msk; ren = re;
    exp_v = v;
    model(addr, size, kind, vb, msk, re, exp_a, exp_f, exp_tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [12];
    bases = '{32'hFE000000, 32'hFE003FF8, 32'hFE004000, 32'hFE7FFFF8,
              32'hFE800000, 32'hFEFEFFF8, 32'hFEFF0600, 32'hFEFF05F8,
              32'hFEFF7FF8, 32'hFEFF8000, 32'h00001000, 32'hFFFFFFF0};
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 6'b0) begin
      failures++;
      $display("FAIL R11 reset actual=%b/%b expected=0/000000", rsp_valid, rsp_fault);
    end
    rst_ni = 1'b1;

    // R4
    step(1, 32'hFE800000, 3, 0, 0, 0, 0);
    step(1, 32'hFE800000, 2, 0, 0, 0, 0);
    step(1, 32'hFEFFFFF8, 3, 0, 0, 0, 0);
    // R5
    step(1, 32'h00001002, 2, 0, 0, 0, 0);
    step(1, 32'h00001002, 2, 0, 0, 1, 0);
    step(1, 32'hFE800004, 3, 1, 0, 0, 0);
    step(1, 32'hFE800004, 3, 1, 0, 1, 0);
    step(1, 32'hFE800004, 3, 0, 0, 0, 0);
    // R6
    step(1, 32'h00000003, 1, 0, 1, 0, 0);
    step(1, 32'hFEFF0601, 2, 0, 1, 0, 0);
    step(1, 32'h0000100C, 4, 0, 1, 0, 0);
    step(1, 32'hFE003FFE, 0, 2, 1, 0, 1);
    // R7
    step(1, 32'hFEFF0600, 2, 0, 1, 0, 0);
    step(1, 32'hFEFF05FC, 2, 0, 1, 0, 0);
    step(1, 32'hFEFF8000, 2, 0, 1, 0, 0);
    step(1, 32'hFE7FFFFC, 2, 0, 1, 0, 0);
    step(1, 32'hFE000000, 0, 1, 1, 0, 0);
    step(0, 32'h0, 0, 0, 0, 0, 0);
    // R8
    step(1, 32'h00000002, 0, 2, 0, 0, 0);
    step(1, 32'hFEFFFFFC, 2, 3, 0, 0, 0);
    step(1, 32'hFF000000, 2, 2, 0, 0, 0);
    // R9
    step(1, 32'hFE003FFC, 2, 2, 1, 0, 0);
    step(1, 32'hFE003FFC, 2, 2, 1, 0, 1);
    step(1, 32'hFE004000, 2, 2, 1, 0, 1);
    step(1, 32'hFE800000, 2, 2, 1, 0, 0);
    // R10
    step(1, 32'hFE800008, 3, 1, 0, 0, 0);
    step(1, 32'hFE800008, 2, 1, 0, 0, 0);
    step(1, 32'hFEFF7FFC, 2, 1, 1, 0, 0);
    step(1, 32'hFE400000, 2, 1, 1, 0, 0);
    step(0, 32'h0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 9) < 8),
           bases[$urandom_range(0, 11)] + 32'($urandom_range(0, 15)),
           3'($urandom_range(0, 5)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end

    // R11: asynchronous reset with a pending result
    step(1, 32'hFE800000, 3, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    req_valid = 1'b1;
    rst_ni = 1'b0;
    #1;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 6'b0) begin
      failures++;
      $display("FAIL R11 mid-run reset actual=%b/%b expected=0/000000", rsp_valid, rsp_fault);
    end
    req_valid = 1'b0;
    exp_v = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    step(1, 32'h00000005, 1, 0, 1, 0, 0);
    step(0, 32'h0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();

    done = 1;
    summary();
    $finish;
  end
endmodule